// File: doc/BRIEF.md
# Sync-Hunting Serial Frame Receiver

The block receives a serial bit stream. Each bit arrives with a one-cycle strobe taken from the bit clock of an external radio device. While idle it hunts for a fixed 32-bit synchronization word. The word sits 24 bits into every frame, so a 56-bit history register already holds the start of the frame when the word completes. From that point the receiver counts the remaining bits of the 640-bit frame and stores the frame, byte by byte, into one of two ping-pong buffers. Software reads the buffers through a simple registered read port.

While the bytes are written, a CRC-32 is run over the 76 data bytes. The result is compared with the 32-bit check sequence that ends the frame. For the buffer just filled, the receiver records a CRC-ok bit, the 4-bit frame-type code from the head of the frame, and an "unknown type" flag. It then raises a one-cycle receive interrupt, switches to the other buffer and goes back to hunting. Receive framing depends only on the incoming stream. Two modem-status input levels are also presented on a registered output.

Top module: `sync_frame_rx`

## Requirements
- R1: After synchronous reset, rx_irq, stat_crc_ok, stat_type, stat_unk and line_lvl are all zero.
- R2: A bit is part of the stream only on a cycle with bit_stb high. While hunting, a frame is recognised only when the last 32 accepted bits equal 0x50EF2993, taken with the first-arrived bit as the MSB. Frame bit 0 is the bit accepted 55 strobes before the last sync bit. Noise without that word never produces an interrupt.
- R3: Frame bit n is stored in byte n/8 of the buffer at bit position 7-(n mod 8), so the first-arrived bit is the MSB. Byte k is read at rd_addr=k with rd_buf selecting the buffer, and rd_data is valid one clock after the address.
- R4: The first frame after reset fills buffer 0. Buffers then alternate frame by frame. The status fields of the other buffer do not change.
- R5: CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, MSB-first, no reflection, no final inversion) is computed over frame bits 0..607. It is compared with bits 608..639, where bit 608 is the MSB. stat_crc_ok[b] is 1 exactly when they match.
- R6: rx_irq is a single-cycle pulse asserted two clock edges after the strobe carrying frame bit 639. The buffer's status fields update on that same edge.
- R7: Frame bits 0..3 (bit 0 as the MSB) form the type code and are stored in stat_type[4b+3:4b]. stat_unk[b] is 1 unless the code is 0000 (sync frame), 1000 (negotiation frame) or 1001 (negotiation with sync).
- R8: A copy of the sync word inside a frame's body does not realign or restart the capture. After 640 bits the receiver hunts again.
- R9: Frames are captured correctly with strobes on consecutive cycles and with idle cycles between strobes.
- R10: line_lvl equals {ri_in, dsr_in} as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received serial bit, valid with bit_stb |
| dsr_in | input | 1 | Data-set-ready input level |
| ri_in | input | 1 | Ring-indicator input level |
| rd_buf | input | 1 | Buffer selected for reading |
| rd_addr | input | 7 | Byte address within the buffer |
| rd_data | output | 8 | Read data, one cycle after the address |
| stat_crc_ok | output | 2 | CRC match flag per buffer |
| stat_type | output | 8 | Type code per buffer, buffer b in bits 4b+3..4b |
| stat_unk | output | 2 | Unrecognised type code flag per buffer |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| line_lvl | output | 2 | Registered {ri_in, dsr_in} |

## Verification
Frames arrive behind random noise gaps of random length, with random idle spacing between strobes. This separates correct alignment on the sync word from alignment that only works for a frame at the stream start. Directed frames carry each known type code and one unknown code, a corrupted check sequence, and a second copy of the sync word in the payload. These tell a correct status word, CRC verdict and capture length apart from a receiver that re-locks mid-frame. Back-to-back strobes with no gap between frames check that the seven history bytes are flushed before the first payload byte completes. A final noise-only stream checks that nothing is ever captured without the sync word.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int BYTE_W = 8;
  localparam int TYPE_W = 4;
  localparam int CRC_W  = 32;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [TYPE_W-1:0] ftype_t;

  localparam crc_t   CRC_POLY   = 32'h04C1_1DB7;
  localparam crc_t   CRC_INIT   = 32'hFFFF_FFFF;
  localparam ftype_t FT_SYNC    = 4'b0000;
  localparam ftype_t FT_NEG     = 4'b1000;
  localparam ftype_t FT_NEGSYNC = 4'b1001;

  // Advance the CRC by one byte, MSB of the byte first.
  function automatic crc_t crc_byte(crc_t c_in, logic [BYTE_W-1:0] d);
    crc_t c;
    logic fb;
    c = c_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic type_known(ftype_t t);
    return (t == FT_SYNC) || (t == FT_NEG) || (t == FT_NEGSYNC);
  endfunction
endpackage

// File: rtl/sfr_sync_hunter.sv
module sfr_sync_hunter #(
  parameter int HIST_W = 56,
  parameter int SYNC_W = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h50EF_2993
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              hunt_en,
  input  logic              hist_clr,
  output logic [HIST_W-1:0] hist,
  output logic              match
);
  logic [HIST_W-1:0] hist_nxt;

  assign hist_nxt = {hist[HIST_W-2:0], bit_in};
  assign match    = bit_stb && hunt_en && (hist_nxt[SYNC_W-1:0] == SYNC_WORD);

  // History only moves while hunting; it is frozen during capture so the
  // controller can drain it into the buffer.
  always_ff @(posedge clk) begin
    if (rst || hist_clr)
      hist <= '0;
    else if (bit_stb && hunt_en)
      hist <= hist_nxt;
  end
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 640,
  parameter int HIST_W     = 56,
  parameter int ADDR_W     = 7,
  parameter int CNT_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              match,
  input  logic [HIST_W-1:0] hist,
  output logic              capturing,
  output logic              hist_clr,
  output logic              wr_en,
  output logic              wr_buf,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output ftype_t            cap_type,
  output logic              flush_act,
  output logic              pend_vld
);
  localparam int FRAME_BYTES = FRAME_BITS / BYTE_W;
  localparam int HIST_BYTES  = HIST_W / BYTE_W;
  localparam int FIDX_W      = $clog2(HIST_BYTES);
  localparam int FSLOTS      = 2 ** FIDX_W;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]  CNT_START = CNT_W'(HIST_W);
  localparam logic [ADDR_W-1:0] IDX_LAST  = ADDR_W'(FRAME_BYTES - 1);
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(HIST_BYTES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] acc;
  logic [BYTE_W-1:0] pend_data;
  logic [ADDR_W-1:0] pend_idx;
  logic [FIDX_W-1:0] fidx;
  logic              last_bit;
  logic [BYTE_W-1:0] hbyte [FSLOTS];

  // Slice the frozen history into bytes, frame byte 0 at the top.
  for (genvar g = 0; g < FSLOTS; g++) begin : g_hslice
    if (g < HIST_BYTES) begin : g_used
      assign hbyte[g] = hist[HIST_W-1-BYTE_W*g -: BYTE_W];
    end else begin : g_pad
      assign hbyte[g] = '0;
    end
  end

  assign last_bit = capturing && bit_stb && (cnt == CNT_LAST);
  assign hist_clr = last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      capturing <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      pend_vld  <= 1'b0;
      pend_data <= '0;
      pend_idx  <= '0;
      flush_act <= 1'b0;
      fidx      <= '0;
      wr_buf    <= 1'b0;
      cap_type  <= '0;
    end else begin
      // write stage: history bytes first, then assembled payload bytes
      if (flush_act) begin
        if (fidx == '0) cap_type <= hist[HIST_W-1 -: TYPE_W];
        if (fidx == FIDX_LAST) flush_act <= 1'b0;
        fidx <= fidx + 1'b1;
      end else if (pend_vld) begin
        pend_vld <= 1'b0;
        if (pend_idx == IDX_LAST) wr_buf <= ~wr_buf;
      end
      // bit stage
      if (match) begin
        capturing <= 1'b1;
        cnt       <= CNT_START;
        flush_act <= 1'b1;
        fidx      <= '0;
      end else if (capturing && bit_stb) begin
        acc <= {acc[BYTE_W-3:0], bit_in};
        cnt <= cnt + 1'b1;
        if (cnt[2:0] == 3'b111) begin
          pend_vld  <= 1'b1;
          pend_data <= {acc, bit_in};
          pend_idx  <= cnt[CNT_W-1:3];
        end
        if (last_bit) capturing <= 1'b0;
      end
    end
  end

  always_comb begin
    wr_en   = flush_act || pend_vld;
    wr_idx  = flush_act ? ADDR_W'(fidx) : pend_idx;
    wr_data = flush_act ? hbyte[fidx] : pend_data;
  end
endmodule

// File: rtl/sfr_crc_status.sv
module sfr_crc_status
  import sfr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int FRAME_BYTES = 80,
  parameter int DATA_BYTES  = 76
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                wr_en,
  input  logic                wr_buf,
  input  logic [ADDR_W-1:0]   wr_idx,
  input  logic [BYTE_W-1:0]   wr_data,
  input  ftype_t              cap_type,
  output logic [1:0]          stat_crc_ok,
  output logic [2*TYPE_W-1:0] stat_type,
  output logic [1:0]          stat_unk,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] DATA_END = ADDR_W'(DATA_BYTES);
  localparam logic [ADDR_W-1:0] IDX_LAST = ADDR_W'(FRAME_BYTES - 1);

  crc_t crc;
  crc_t fcs;
  crc_t fcs_nxt;

  assign fcs_nxt = {fcs[CRC_W-BYTE_W-1:0], wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      crc         <= CRC_INIT;
      fcs         <= '0;
      stat_crc_ok <= '0;
      stat_type   <= '0;
      stat_unk    <= '0;
      irq         <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        crc <= CRC_INIT;
      end else if (wr_en) begin
        if (wr_idx < DATA_END) crc <= crc_byte(crc, wr_data);
        else                   fcs <= fcs_nxt;
        if (wr_idx == IDX_LAST) begin
          stat_crc_ok[wr_buf]                  <= (crc == fcs_nxt);
          stat_type[wr_buf*TYPE_W +: TYPE_W]   <= cap_type;
          stat_unk[wr_buf]                     <= !type_known(cap_type);
          irq                                  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfr_pp_ram.sv
module sfr_pp_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_buf,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** (ADDR_W + 1);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_buf, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[{rd_buf, rd_idx}];
  end
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS = 640,
  parameter int SYNC_POS   = 24,
  parameter int SYNC_W     = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h50EF_2993,
  parameter int ADDR_W     = $clog2(FRAME_BITS / BYTE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                bit_in,
  input  logic                dsr_in,
  input  logic                ri_in,
  input  logic                rd_buf,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [1:0]          stat_crc_ok,
  output logic [2*TYPE_W-1:0] stat_type,
  output logic [1:0]          stat_unk,
  output logic                rx_irq,
  output logic [1:0]          line_lvl
);
  localparam int HIST_W      = SYNC_POS + SYNC_W;
  localparam int FRAME_BYTES = FRAME_BITS / BYTE_W;
  localparam int DATA_BYTES  = FRAME_BYTES - CRC_W / BYTE_W;
  localparam int CNT_W       = $clog2(FRAME_BITS);

  logic [HIST_W-1:0] hist;
  logic              match;
  logic              capturing;
  logic              hist_clr;
  logic              wr_en;
  logic              wr_buf;
  logic [ADDR_W-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data;
  ftype_t            cap_type;
  logic              flush_act;
  logic              pend_vld;

  sfr_sync_hunter #(
    .HIST_W(HIST_W), .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)
  ) u_hunt (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .hunt_en(!capturing), .hist_clr(hist_clr), .hist(hist), .match(match)
  );

  sfr_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .match(match), .hist(hist), .capturing(capturing), .hist_clr(hist_clr),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(wr_data),
    .cap_type(cap_type), .flush_act(flush_act), .pend_vld(pend_vld)
  );

  sfr_crc_status #(
    .ADDR_W(ADDR_W), .FRAME_BYTES(FRAME_BYTES), .DATA_BYTES(DATA_BYTES)
  ) u_stat (
    .clk(clk), .rst(rst), .start(match), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_idx(wr_idx), .wr_data(wr_data), .cap_type(cap_type),
    .stat_crc_ok(stat_crc_ok), .stat_type(stat_type), .stat_unk(stat_unk),
    .irq(rx_irq)
  );

  sfr_pp_ram #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W)
  ) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_buf(rd_buf), .rd_idx(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) line_lvl <= '0;
    else     line_lvl <= {ri_in, dsr_in};
  end
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk
  import sfr_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                rx_irq,
  input logic [1:0]          stat_crc_ok,
  input logic [2*TYPE_W-1:0] stat_type,
  input logic [1:0]          stat_unk,
  input logic                dsr_in,
  input logic                ri_in,
  input logic [1:0]          line_lvl,
  input logic                flush_act,
  input logic                pend_vld
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq); // R6

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_irq |-> ($stable(stat_crc_ok) && $stable(stat_type) && $stable(stat_unk))); // R4

  AST_UNK_LO: assert property (@(posedge clk) disable iff (rst)
    stat_unk[0] == !type_known(stat_type[TYPE_W-1:0])); // R7

  AST_UNK_HI: assert property (@(posedge clk) disable iff (rst)
    stat_unk[1] == !type_known(stat_type[2*TYPE_W-1:TYPE_W])); // R7

  AST_LINE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (line_lvl == $past({ri_in, dsr_in}))); // R10

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    pend_vld |-> !flush_act); // R9
endmodule

bind sync_frame_rx sfr_rx_chk u_chk (
  .clk(clk), .rst(rst), .rx_irq(rx_irq), .stat_crc_ok(stat_crc_ok),
  .stat_type(stat_type), .stat_unk(stat_unk), .dsr_in(dsr_in),
  .ri_in(ri_in), .line_lvl(line_lvl), .flush_act(flush_act),
  .pend_vld(pend_vld)
);

// File: tb/tb_sync_frame_rx.sv
`timescale 1ns/1ps
module tb_sync_frame_rx;
  localparam int NBITS = 640;
  localparam int NBYTES = 80;
  localparam logic [31:0] SYNC = 32'h50EF_2993;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0, bit_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0;
  logic rd_buf = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] stat_crc_ok, stat_unk, line_lvl;
  logic [7:0] stat_type;
  logic rx_irq;

  int checks = 0, errors = 0, cycles = 0, irq_cnt = 0;
  bit fr [NBITS];
  bit st [0:1023];
  int st_len;
  logic [31:0] win = '0;
  bit exp_buf = 1'b0;

  always #10 clk = ~clk;

  sync_frame_rx dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .dsr_in(dsr_in), .ri_in(ri_in), .rd_buf(rd_buf), .rd_addr(rd_addr),
    .rd_data(rd_data), .stat_crc_ok(stat_crc_ok), .stat_type(stat_type),
    .stat_unk(stat_unk), .rx_irq(rx_irq), .line_lvl(line_lvl)
  );

  always @(posedge clk) begin
    if (!rst && rx_irq) irq_cnt++;
    cycles++;
    if (cycles == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 608; i++) begin
      logic fb = c[31] ^ fr[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic type_ok(logic [3:0] t);
    return t == 4'b0000 || t == 4'b1000 || t == 4'b1001;
  endfunction

  task automatic build_frame(input logic [3:0] typ, input bit good, input bit embed);
    logic [31:0] c;
    for (int i = 0; i < NBITS; i++) fr[i] = bit'($urandom_range(1, 0));
    for (int i = 0; i < 4; i++) fr[i] = typ[3-i];
    for (int i = 0; i < 32; i++) fr[24+i] = SYNC[31-i];
    if (embed) for (int i = 0; i < 32; i++) fr[200+i] = SYNC[31-i];
    c = model_crc();
    for (int i = 0; i < 32; i++) fr[608+i] = c[31-i];
    if (!good) fr[620] = ~fr[620];
  endtask

  // first sync hit in st, starting from the hunter's current window
  function automatic int first_hit();
    logic [31:0] w = win;
    for (int i = 0; i < st_len; i++) begin
      w = {w[30:0], st[i]};
      if (w == SYNC) return i;
    end
    return -1;
  endfunction

  task automatic drive_bit(input bit b, input int idles);
    bit_in = b; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (idles) @(negedge clk);
  endtask

  task automatic run_frame(input logic [3:0] typ, input bit good, input bit embed,
                           input int gap, input int idle_max, input string tag);
    int tries = 0, irq0, mism = 0;
    logic [7:0] got, exp, bad_got = '0, bad_exp = '0;
    logic [1:0] o_ok, o_unk;
    logic [7:0] o_typ;
    bit ob;
    do begin
      build_frame(typ, good, embed);
      for (int i = 0; i < gap; i++) st[i] = bit'($urandom_range(1, 0));
      for (int i = 0; i < NBITS; i++) st[gap+i] = fr[i];
      st_len = gap + NBITS;
      tries++;
    end while (first_hit() != gap + 55 && tries < 50);
    ob = ~exp_buf;
    o_ok = stat_crc_ok; o_unk = stat_unk; o_typ = stat_type;
    irq0 = irq_cnt;
    for (int i = 0; i < st_len; i++)
      drive_bit(st[i], (i == st_len - 1) ? 0 : $urandom_range(idle_max, 0));
    chk(rx_irq == 1'b0, {tag, " R6 irq not before 2nd edge"}, rx_irq, 0);
    chk(irq_cnt == irq0, {tag, " R8 no early or extra irq"}, irq_cnt, irq0);
    @(negedge clk);
    chk(rx_irq == 1'b1, {tag, " R6 irq on 2nd edge"}, rx_irq, 1);
    chk(stat_crc_ok[exp_buf] == good, {tag, " R5 crc verdict"}, stat_crc_ok[exp_buf], good);
    chk(stat_type[exp_buf*4 +: 4] == typ, {tag, " R7 type code"}, stat_type[exp_buf*4 +: 4], typ);
    chk(stat_unk[exp_buf] == !type_ok(typ), {tag, " R7 unknown flag"}, stat_unk[exp_buf], !type_ok(typ));
    chk(stat_crc_ok[ob] == o_ok[ob] && stat_unk[ob] == o_unk[ob] &&
        stat_type[ob*4 +: 4] == o_typ[ob*4 +: 4], {tag, " R4 other buffer untouched"},
        {stat_crc_ok[ob], stat_type[ob*4 +: 4]}, {o_ok[ob], o_typ[ob*4 +: 4]});
    @(negedge clk);
    chk(rx_irq == 1'b0, {tag, " R6 single-cycle irq"}, rx_irq, 0);
    for (int k = 0; k < NBYTES; k++) begin
      rd_buf = exp_buf; rd_addr = 7'(k);
      @(negedge clk);
      got = rd_data;
      for (int j = 0; j < 8; j++) exp[7-j] = fr[8*k+j];
      if (got !== exp && mism == 0) begin bad_got = got; bad_exp = exp; end
      if (got !== exp) mism++;
    end
    chk(mism == 0, {tag, " R2 R3 frame bytes in buffer"}, bad_got, bad_exp);
    exp_buf = ~exp_buf;
    win = '0;
  endtask

  initial begin
    int irq0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_irq == 0 && stat_crc_ok == 0 && stat_unk == 0, "R1 reset flags",
        {rx_irq, stat_crc_ok, stat_unk}, 0);
    chk(stat_type == 0 && line_lvl == 0, "R1 reset type/lines", {stat_type, line_lvl}, 0);
    // R10 line levels
    for (int i = 0; i < 8; i++) begin
      dsr_in = bit'($urandom_range(1, 0)); ri_in = bit'($urandom_range(1, 0));
      @(negedge clk);
      chk(line_lvl == {ri_in, dsr_in}, "R10 line levels", line_lvl, {ri_in, dsr_in});
    end
    // directed frames
    run_frame(4'b0000, 1'b1, 1'b0, 7, 2, "sync-type");
    run_frame(4'b1000, 1'b1, 1'b0, 13, 1, "neg-type");
    run_frame(4'b1001, 1'b0, 1'b0, 3, 2, "bad-fcs R5");
    run_frame(4'b0101, 1'b1, 1'b0, 0, 1, "unknown R7");
    run_frame(4'b1000, 1'b1, 1'b1, 9, 2, "embedded-sync R8");
    run_frame(4'b1001, 1'b1, 1'b0, 0, 0, "back-to-back R9");
    run_frame(4'b0000, 1'b0, 1'b0, 0, 0, "back-to-back R9");
    // random frames
    for (int n = 0; n < 8; n++) begin
      logic [3:0] t;
      case ($urandom_range(3, 0))
        0: t = 4'b0000;
        1: t = 4'b1000;
        2: t = 4'b1001;
        default: t = 4'($urandom_range(15, 0));
      endcase
      run_frame(t, $urandom_range(3, 0) != 0, 1'b0, $urandom_range(20, 0),
                $urandom_range(2, 0), "random");
    end
    // R2 noise without sync word never captures
    st_len = 300;
    do begin
      for (int i = 0; i < st_len; i++) st[i] = bit'($urandom_range(1, 0));
    end while (first_hit() != -1);
    irq0 = irq_cnt;
    for (int i = 0; i < st_len; i++) drive_bit(st[i], $urandom_range(1, 0));
    repeat (4) @(negedge clk);
    chk(irq_cnt == irq0, "R2 noise gives no irq", irq_cnt, irq0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule